// File: doc/BRIEF.md
# Multichannel ADC register front-end

This block sits between a simple 32-bit register bus and an eight-input successive-approximation converter core. Software selects an input and sets a start bit in the configuration word. The block then strobes the core once, captures the 10-bit result together with the channel it belongs to, raises an end-of-conversion flag and advances a completion counter. The core is driven through plain ports: a power-down level, a one-cycle convert strobe and a channel select going out, and a done pulse with its data coming back.

The core needs a settling time after it leaves power-down. When the core is powered up, the block loads a settling counter. A start request made while that counter runs is held pending and goes to the core on the first cycle after the counter expires. A start request made while the core is powered down is discarded. Software can read back the sampled channel to confirm which input produced the current result.

Top module: `adc_regfront`

## Requirements
- R1: After reset, every register reads zero except the power register, which reads 1 (powered down), and `core_conv` is low.
- R2: Register offsets and fields are as follows. Configuration is at 0x00, with bits [2:0] the channel, bit 4 the start/pending bit and bit 5 the single-conversion flag. Result is at 0x04 in bits [9:0]. End-of-conversion is at 0x08 bit 0. Sampled channel is at 0x0C bits [2:0]. Power is at 0x10 bit 0. Debug is at 0x14, with bit 0 a start pending and bit 1 a conversion in flight. The completion counter is at 0x20. All other bits and every unmapped offset read zero.
- R3: Writing 0 to the power register while the core is powered down loads a settling count of SETTLE_CYC (default 8, and at least 6). A pending start reaches `core_conv` exactly SETTLE_CYC+1 cycles after the power-up write takes effect.
- R4: A configuration write with bit 4 set while powered down updates the channel and single-mode fields but drops the start: bit 4 reads 0 and no strobe is issued.
- R5: Once settled, a start write produces a one-cycle `core_conv` on the next cycle, and the start bit reads 0 from that cycle on.
- R6: A start write clears end-of-conversion. A `core_done` while a conversion is in flight sets end-of-conversion, stores `core_data` as the result and stores the issued channel as the sampled channel.
- R7: The completion counter (CNT_W bits) increments by one on each completed conversion and wraps to zero.
- R8: A `core_done` pulse while no conversion is in flight changes neither the result nor the counter.
- R9: Configuration writes are ignored while a start is pending or a conversion is in flight. Writes to the result, end-of-conversion, sampled-channel, debug and counter offsets change nothing.
- R10: Writing 1 to the power register drops a pending start and abandons an in-flight conversion, so its later done pulse is ignored. Writing 0 while already powered up does not restart the settling count.
- R11: `core_chan` carries the channel of the most recent accepted start and holds it until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr when bus_sel is high |
| core_pwrdn | output | 1 | Power-down level to the core |
| core_conv | output | 1 | One-cycle convert strobe |
| core_chan | output | CH_W | Channel select for the conversion |
| core_done | input | 1 | Conversion finished pulse from the core |
| core_data | input | DATA_W | Conversion result from the core |

## Verification
A settling counter that is wrong by one cycle moves the strobe off its exact cycle after power-up, and the bench compares `core_conv` against its model on every cycle, so the error shows within one clock. A lost or stuck pending flag shows up at once in the debug and configuration read-back. It also shows up as a strobe that is missing or extra on the same cycle. A wrong in-flight state shows on the next done pulse: spurious or abandoned completions would alter the result, end-of-conversion or counter, which are read back right after that pulse. A channel latched at the wrong moment appears at `core_chan` on the strobe cycle and in the sampled-channel register after completion.

// File: rtl/adc_regfront_pkg.sv
package adc_regfront_pkg;
    localparam logic [7:0] OFS_CFG  = 8'h00;
    localparam logic [7:0] OFS_RES  = 8'h04;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_SRC  = 8'h0C;
    localparam logic [7:0] OFS_PWR  = 8'h10;
    localparam logic [7:0] OFS_DBG  = 8'h14;
    localparam logic [7:0] OFS_CNT  = 8'h20;

    localparam int CFG_GO_BIT     = 4;
    localparam int CFG_SINGLE_BIT = 5;
    localparam int PWR_BIT        = 0;
    localparam int DBG_PEND_BIT   = 0;
    localparam int DBG_BUSY_BIT   = 1;
endpackage

// File: rtl/adc_settle_ctr.sv
module adc_settle_ctr #(
    parameter int SETTLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic load,
    input  logic clear,
    output logic ready
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (load) begin
            cnt_d = CW'(SETTLE_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = !pwr_dn && (cnt_q == '0);

    // R3: the first powered-up cycle is never ready
    p_settle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_dn) |-> !ready);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int CH_W   = 3,
    parameter int DATA_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              ready,
    input  logic              abort,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_data,
    output logic              core_conv,
    output logic [CH_W-1:0]   core_chan,
    output logic              go_pend,
    output logic              busy,
    output logic              eoc,
    output logic [DATA_W-1:0] result,
    output logic [CH_W-1:0]   src_chan,
    output logic [CNT_W-1:0]  done_cnt
);
    typedef struct packed {
        logic              go;
        logic              busy;
        logic              conv;
        logic              eoc;
        logic [CH_W-1:0]   ichan;
        logic [DATA_W-1:0] result;
        logic [CH_W-1:0]   src;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.conv = 1'b0;
        if (core_done && s_q.busy) begin
            s_d.result = core_data;
            s_d.src    = s_q.ichan;
            s_d.eoc    = 1'b1;
            s_d.cnt    = s_q.cnt + 1'b1;
            s_d.busy   = 1'b0;
        end
        if (s_q.go && ready && !abort) begin
            s_d.go   = 1'b0;
            s_d.busy = 1'b1;
            s_d.conv = 1'b1;
        end
        if (start_req) begin
            s_d.go    = 1'b1;
            s_d.eoc   = 1'b0;
            s_d.ichan = req_chan;
        end
        if (abort) begin
            s_d.go   = 1'b0;
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign core_conv = s_q.conv;
    assign core_chan = s_q.ichan;
    assign go_pend   = s_q.go;
    assign busy      = s_q.busy;
    assign eoc       = s_q.eoc;
    assign result    = s_q.result;
    assign src_chan  = s_q.src;
    assign done_cnt  = s_q.cnt;

    p_conv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.conv |=> !s_q.conv);

    p_go_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.go) |-> (s_q.conv || $past(abort)));

    p_eoc_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.eoc) |-> $past(core_done));

    p_idle_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !s_q.busy) |=> $stable(s_q.result));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != $past(s_q.cnt)) |-> (s_q.cnt == CNT_W'($past(s_q.cnt) + 1'b1)));
endmodule

// File: rtl/adc_regfront.sv
module adc_regfront
    import adc_regfront_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int DATA_W     = 10,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 8,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              core_pwrdn,
    output logic              core_conv,
    output logic [CH_W-1:0]   core_chan,
    input  logic              core_done,
    input  logic [DATA_W-1:0] core_data
);
    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            single;
        logic            pwrdn;
    } cfg_t;

    cfg_t c_d, c_q;

    logic              wr_hit;
    logic              cfg_take, start_req, pd_set, pu_evt;
    logic              ready, go_pend, busy, eoc;
    logic [DATA_W-1:0] result;
    logic [CH_W-1:0]   src_chan;
    logic [CNT_W-1:0]  done_cnt;
    logic              unused_wdata;

    assign wr_hit       = bus_sel && bus_wr;
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        c_d       = c_q;
        cfg_take  = wr_hit && (bus_addr == OFS_CFG) && !go_pend && !busy;
        start_req = cfg_take && bus_wdata[CFG_GO_BIT] && !c_q.pwrdn;
        pd_set    = wr_hit && (bus_addr == OFS_PWR) && bus_wdata[PWR_BIT];
        pu_evt    = wr_hit && (bus_addr == OFS_PWR) && !bus_wdata[PWR_BIT] && c_q.pwrdn;
        if (cfg_take) begin
            c_d.chan   = bus_wdata[CH_W-1:0];
            c_d.single = bus_wdata[CFG_SINGLE_BIT];
        end
        if (pd_set)      c_d.pwrdn = 1'b1;
        else if (pu_evt) c_d.pwrdn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{chan: '0, single: 1'b0, pwrdn: 1'b1};
        else        c_q <= c_d;
    end

    adc_settle_ctr #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_dn (c_q.pwrdn),
        .load   (pu_evt),
        .clear  (pd_set),
        .ready  (ready)
    );

    adc_conv_seq #(.CH_W(CH_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .req_chan  (bus_wdata[CH_W-1:0]),
        .ready     (ready),
        .abort     (pd_set),
        .core_done (core_done),
        .core_data (core_data),
        .core_conv (core_conv),
        .core_chan (core_chan),
        .go_pend   (go_pend),
        .busy      (busy),
        .eoc       (eoc),
        .result    (result),
        .src_chan  (src_chan),
        .done_cnt  (done_cnt)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                OFS_CFG: begin
                    bus_rdata[CH_W-1:0]      = c_q.chan;
                    bus_rdata[CFG_GO_BIT]     = go_pend;
                    bus_rdata[CFG_SINGLE_BIT] = c_q.single;
                end
                OFS_RES:  bus_rdata[DATA_W-1:0] = result;
                OFS_STAT: bus_rdata[0]          = eoc;
                OFS_SRC:  bus_rdata[CH_W-1:0]   = src_chan;
                OFS_PWR:  bus_rdata[PWR_BIT]    = c_q.pwrdn;
                OFS_DBG: begin
                    bus_rdata[DBG_PEND_BIT] = go_pend;
                    bus_rdata[DBG_BUSY_BIT] = busy;
                end
                OFS_CNT:  bus_rdata[CNT_W-1:0]  = done_cnt;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign core_pwrdn = c_q.pwrdn;

    // cycles spent powered up, saturating; used only by the checks below
    logic [3:0] up_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               up_cnt_q <= '0;
        else if (c_q.pwrdn)       up_cnt_q <= '0;
        else if (up_cnt_q != 4'hF) up_cnt_q <= up_cnt_q + 1'b1;
    end

    p_min_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_conv |-> (up_cnt_q >= 4'd6));

    p_conv_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        core_conv |-> !core_pwrdn);
endmodule

// File: tb/adc_regfront_tb.sv
module adc_regfront_tb;
    localparam int CLK_NS = 10;
    localparam int NUM_CH = 8;
    localparam int DATA_W = 10;
    localparam int CNT_W  = 4;
    localparam int SETTLE = 8;
    localparam int LAT    = 5;

    logic        clk, rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        core_pwrdn, core_conv, core_done;
    logic [2:0]  core_chan;
    logic [9:0]  core_data;

    adc_regfront #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_pwrdn(core_pwrdn), .core_conv(core_conv), .core_chan(core_chan),
        .core_done(core_done), .core_data(core_data)
    );

    initial clk = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit run_chk = 0, spur = 0;
    int stub_cnt = 0, stub_val = 17;

    int m_pd = 1, m_settle = 0, m_go = 0, m_busy = 0, m_conv = 0, m_eoc = 0;
    int m_data = 0, m_src = 0, m_cnt = 0, m_ichan = 0, m_cchan = 0, m_single = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int m_read(input logic [7:0] a);
        case (a)
            8'h00: return (m_single << 5) | (m_go << 4) | m_cchan;
            8'h04: return m_data;
            8'h08: return m_eoc;
            8'h0C: return m_src;
            8'h10: return m_pd;
            8'h14: return (m_busy << 1) | m_go;
            8'h20: return m_cnt;
            default: return 0;
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit wr, pdw, puw, cfgw, st, rdy, iss;
        cyc++;
        if (!rst_n) begin
            m_pd = 1; m_settle = 0; m_go = 0; m_busy = 0; m_conv = 0; m_eoc = 0;
            m_data = 0; m_src = 0; m_cnt = 0; m_ichan = 0; m_cchan = 0; m_single = 0;
        end else begin
            wr   = bus_sel && bus_wr;
            pdw  = wr && bus_addr == 8'h10 && bus_wdata[0];
            puw  = wr && bus_addr == 8'h10 && !bus_wdata[0] && m_pd == 1;
            cfgw = wr && bus_addr == 8'h00 && m_go == 0 && m_busy == 0;
            st   = cfgw && bus_wdata[4] && m_pd == 0;
            rdy  = m_pd == 0 && m_settle == 0;
            iss  = m_go == 1 && rdy && !pdw;
            m_conv = 0;
            if (core_done && m_busy == 1) begin
                m_data = int'(core_data); m_src = m_ichan; m_eoc = 1;
                m_cnt = (m_cnt + 1) % (1 << CNT_W); m_busy = 0;
            end
            if (iss) begin m_go = 0; m_busy = 1; m_conv = 1; end
            if (st) begin m_go = 1; m_eoc = 0; m_ichan = int'(bus_wdata[2:0]); end
            if (pdw) begin m_go = 0; m_busy = 0; end
            if (cfgw) begin m_cchan = int'(bus_wdata[2:0]); m_single = int'(bus_wdata[5]); end
            if (pdw) m_settle = 0;
            else if (puw) m_settle = SETTLE;
            else if (m_settle > 0) m_settle--;
            if (pdw) m_pd = 1;
            else if (puw) m_pd = 0;
        end
    end

    // per-cycle port comparison (R3, R5, R11, R10)
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            check(int'(core_conv) == m_conv, "R5 core_conv", int'(core_conv), m_conv);
            check(int'(core_chan) == m_ichan, "R11 core_chan", int'(core_chan), m_ichan);
            check(int'(core_pwrdn) == m_pd, "R10 core_pwrdn", int'(core_pwrdn), m_pd);
        end
    end

    // converter stub
    always @(negedge clk) begin
        core_done = 1'b0;
        if (spur) begin
            core_done = 1'b1; core_data = 10'h3AA; spur = 0;
        end else if (core_conv) begin
            stub_cnt = LAT;
        end else if (stub_cnt > 0) begin
            stub_cnt--;
            if (stub_cnt == 0) begin
                stub_val = (stub_val * 37 + 11) % 1024;
                core_done = 1'b1;
                core_data = stub_val[9:0];
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input int exp, input string req);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        check(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
        bus_sel = 0;
    endtask

    task automatic rd_m(input logic [7:0] a, input string req);
        int exp;
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1;
        exp = m_read(a);
        check(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
        bus_sel = 0;
    endtask

    task automatic wait_conv();
        while (!core_conv) @(negedge clk);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_go == 1 || m_busy == 1 || stub_cnt > 0);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, res;
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        core_done = 0; core_data = 0;
        repeat (4) @(negedge clk);
        rst_n = 1; run_chk = 1;

        // R1 / R2 reset values and unmapped offsets
        rd_exp(8'h00, 0, "R1 cfg");
        rd_exp(8'h04, 0, "R1 result");
        rd_exp(8'h08, 0, "R1 eoc");
        rd_exp(8'h0C, 0, "R1 src");
        rd_exp(8'h10, 1, "R1 pwr");
        rd_exp(8'h14, 0, "R1 dbg");
        rd_exp(8'h20, 0, "R1 cnt");
        rd_exp(8'h18, 0, "R2 unmapped");
        rd_exp(8'h24, 0, "R2 unmapped");

        // R4 start while powered down
        wr(8'h00, 32'h13);
        repeat (3) @(negedge clk);
        rd_exp(8'h00, 32'h03, "R4 cfg");
        rd_exp(8'h14, 0, "R4 dbg");

        // R3 start held through settling
        wr(8'h10, 0);
        t0 = cyc;
        wr(8'h00, 32'h15);
        rd_exp(8'h14, 1, "R3 pending");
        rd_exp(8'h00, 32'h15, "R2 cfg pending");
        wait_conv();
        check(cyc - t0 == SETTLE + 1, "R3 settle delay", cyc - t0, SETTLE + 1);
        check(int'(core_chan) == 5, "R11 chan", int'(core_chan), 5);
        rd_exp(8'h00, 32'h05, "R5 go self-clear");
        rd_exp(8'h14, 2, "R2 dbg busy");
        wait_idle();
        rd_m(8'h04, "R6 result");
        rd_exp(8'h08, 1, "R6 eoc");
        rd_exp(8'h0C, 5, "R6 src");
        rd_exp(8'h20, 1, "R7 count");

        // R8 spurious done
        res = m_data;
        @(posedge clk); #1 spur = 1;
        repeat (3) @(negedge clk);
        rd_exp(8'h04, res, "R8 result");
        rd_exp(8'h20, 1, "R8 count");

        // R9 writes ignored while pending/busy and to read-only offsets
        wr(8'h00, 32'h12);
        wr(8'h00, 32'h37);
        rd_exp(8'h00, 32'h02, "R9 cfg");
        wait_idle();
        rd_exp(8'h0C, 2, "R9 src");
        wr(8'h04, 32'hFFFFFFFF);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h7);
        wr(8'h14, 32'h3);
        wr(8'h20, 32'hFFFF);
        rd_m(8'h04, "R9 result");
        rd_exp(8'h08, 1, "R9 eoc");
        rd_exp(8'h0C, 2, "R9 src");
        rd_exp(8'h14, 0, "R9 dbg");
        rd_exp(8'h20, 2, "R9 cnt");

        // R10 power-up while up does not restart settling; R5 next-cycle strobe
        wr(8'h10, 0);
        wr(8'h00, 32'h11);
        t0 = cyc;
        wait_conv();
        check(cyc - t0 == 1, "R5 strobe next cycle", cyc - t0, 1);
        wait_idle();

        // R10 power-down abandons an in-flight conversion
        wr(8'h00, 32'h16);
        wait_conv();
        wr(8'h10, 1);
        repeat (LAT + 4) @(negedge clk);
        rd_exp(8'h08, 0, "R10 eoc");
        rd_exp(8'h14, 0, "R10 dbg");
        rd_exp(8'h20, 3, "R10 cnt");

        // R10 power-down drops a pending start
        wr(8'h10, 0);
        wr(8'h00, 32'h14);
        wr(8'h10, 1);
        repeat (12) @(negedge clk);
        rd_exp(8'h00, 32'h04, "R10 pending dropped");

        // R7 counter wrap, R11 channel sweep, R6 start clears eoc
        wr(8'h10, 0);
        repeat (SETTLE + 2) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            wr(8'h00, 32'h10 | (i % 8));
            if (i == 0) rd_exp(8'h08, 0, "R6 start clears eoc");
            wait_idle();
            rd_exp(8'h0C, i % 8, "R11 src sweep");
            if (i == 12) rd_exp(8'h20, 0, "R7 wrap");
        end
        rd_exp(8'h20, 3, "R7 final count");

        wr(8'h00, 32'h21);
        rd_exp(8'h00, 32'h21, "R2 single flag");

        run_chk = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule